// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by fetching two levels of translation entries from memory. The requester hands over an address on a valid/ready request channel. The walker looks up the entry for that address in the per-process first-level directory, whose physical base sits in a register inside the block. The entry it finds either maps a 4 MiB page outright or points to a second-level table of 4 KiB pages. In the second case one more read fetches the leaf entry. An entry with its present flag clear at either level ends the walk with a fault.

All memory traffic goes through one read port. That port has a valid/ready request channel and a valid/ready response channel, and only one read is in flight at any moment. On every channel a transfer happens on a clock edge where both valid and ready are high. A source that raises valid keeps it high, with its payload steady, until that edge. The result channel follows the same rule. The walker therefore holds the translation, the fault flag and the large-page flag until the requester takes them. No new request is accepted before then.

Top module: `pt_walker`

## Requirements
- R1: The address splits into a directory index in bits 31..22, a table index in bits 21..12 and a page offset in bits 11..0. The first read of a walk goes to base + 4 × directory index.
- R2: When the directory entry has bit 0 set and bit 7 clear, the second read goes to {entry[31:12], 12'b0} + 4 × table index.
- R3: After a second-level entry with bit 0 set, the result is {leaf[31:12], va[11:0]}, with fault = 0 and large = 0.
- R4: A directory entry with bit 0 and bit 7 both set ends the walk after that single read. The result is {entry[31:22], va[21:0]}, with large = 1 and fault = 0.
- R5: A directory entry with bit 0 clear ends the walk after one read, whatever bit 7 holds. The result has fault = 1, large = 0 and physical address 0.
- R6: A second-level entry with bit 0 clear ends the walk after two reads, with fault = 1 and physical address 0.
- R7: Bit 7 of a second-level entry has no effect on the translation.
- R8: At most one memory read is outstanding. A raised read request holds valid and address until accepted. Response ready is high only while a read is awaiting its data.
- R9: req_ready is high only when the walker is idle. A request presented while a walk or an unconsumed result is pending starts no memory read.
- R10: A result stays valid and unchanged until res_ready is seen high. The walker is then idle on the next cycle.
- R11: A base_load pulse writes base_value into the base register. The walk in progress keeps the directory address it captured when it accepted its request, and later walks use the new base.
- R12: After reset, req_ready = 1, res_valid = 0, mem_req_valid = 0, mem_rsp_ready = 0, and the base register holds 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_load | input | 1 | Write pulse for the directory base register |
| base_value | input | 32 | New directory base physical address |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Linear address to translate |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts read request |
| mem_req_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker waiting for read data |
| mem_rsp_data | input | 32 | Entry read from memory |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Requester takes the result |
| res_paddr | output | 32 | Physical address, 0 on fault |
| res_fault | output | 1 | Walk ended on a non-present entry |
| res_large | output | 1 | Translation came from a 4 MiB mapping |

## Verification
The hardest case to reach from the ports is a base register write that lands inside a walk, after the request is accepted and before the first read is issued. The bench stalls the memory request channel for several cycles and pulses base_load during that window. It then checks that the logged directory read address still uses the old base, and that the next walk uses the new one. A second hard case is a request offered while a result is held. The bench holds res_ready low, presents a fresh request, and watches the read counter and the result pins over those cycles.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RD_DIR   = 3'd1,
    ST_WAIT_DIR = 3'd2,
    ST_RD_TBL   = 3'd3,
    ST_WAIT_TBL = 3'd4,
    ST_DONE     = 3'd5
  } walk_state_e;
endpackage

// File: rtl/pt_base_reg.sv
module pt_base_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] value,
  output logic [AW-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n)    base <= '0;
    else if (load) base <= value;
  end
endmodule

// File: rtl/pt_entry_dec.sv
module pt_entry_dec #(
  parameter int AW        = 32,
  parameter int OFF_W     = 12,
  parameter int TBL_W     = 10,
  parameter int VALID_BIT = 0,
  parameter int LARGE_BIT = 7
) (
  input  logic [AW-1:0] entry,
  input  logic [AW-1:0] vaddr,
  output logic          ent_valid,
  output logic          ent_large,
  output logic [AW-1:0] tbl_addr,
  output logic [AW-1:0] small_pa,
  output logic [AW-1:0] large_pa
);
  localparam int BIG_OFF = OFF_W + TBL_W;
  localparam int STRIDE  = 2;

  logic [AW-1:0] frame_base;
  logic [AW-1:0] tbl_off;

  always_comb begin
    ent_valid  = entry[VALID_BIT];
    ent_large  = entry[LARGE_BIT];
    frame_base = {entry[AW-1:OFF_W], {OFF_W{1'b0}}};
    tbl_off    = AW'(vaddr[BIG_OFF-1:OFF_W]) << STRIDE;
    tbl_addr   = frame_base + tbl_off;
    small_pa   = {entry[AW-1:OFF_W], vaddr[OFF_W-1:0]};
    large_pa   = {entry[AW-1:BIG_OFF], vaddr[BIG_OFF-1:0]};
  end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_vaddr,
  input  logic [AW-1:0] dir_addr,
  output logic          req_ready,
  output logic [AW-1:0] vaddr_q,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic          ent_valid,
  input  logic          ent_large,
  input  logic [AW-1:0] tbl_addr,
  input  logic [AW-1:0] small_pa,
  input  logic [AW-1:0] large_pa,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_paddr,
  output logic          res_fault,
  output logic          res_large
);
  walk_state_e   state;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      vaddr_q   <= '0;
      addr_q    <= '0;
      res_paddr <= '0;
      res_fault <= 1'b0;
      res_large <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          vaddr_q <= req_vaddr;
          addr_q  <= dir_addr;
          state   <= ST_RD_DIR;
        end
        ST_RD_DIR: if (mem_req_ready) state <= ST_WAIT_DIR;
        ST_WAIT_DIR: if (mem_rsp_valid) begin
          if (!ent_valid) begin
            res_paddr <= '0;
            res_fault <= 1'b1;
            res_large <= 1'b0;
            state     <= ST_DONE;
          end else if (ent_large) begin
            res_paddr <= large_pa;
            res_fault <= 1'b0;
            res_large <= 1'b1;
            state     <= ST_DONE;
          end else begin
            addr_q <= tbl_addr;
            state  <= ST_RD_TBL;
          end
        end
        ST_RD_TBL: if (mem_req_ready) state <= ST_WAIT_TBL;
        ST_WAIT_TBL: if (mem_rsp_valid) begin
          res_paddr <= ent_valid ? small_pa : '0;
          res_fault <= !ent_valid;
          res_large <= 1'b0;
          state     <= ST_DONE;
        end
        ST_DONE: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (state == ST_IDLE);
    mem_req_valid = (state == ST_RD_DIR) || (state == ST_RD_TBL);
    mem_rsp_ready = (state == ST_WAIT_DIR) || (state == ST_WAIT_TBL);
    res_valid     = (state == ST_DONE);
    mem_req_addr  = addr_q;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW        = 32,
  parameter int OFF_W     = 12,
  parameter int TBL_W     = 10,
  parameter int DIR_W     = 10,
  parameter int VALID_BIT = 0,
  parameter int LARGE_BIT = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_load,
  input  logic [AW-1:0] base_value,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  output logic          mem_rsp_ready,
  input  logic [AW-1:0] mem_rsp_data,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [AW-1:0] res_paddr,
  output logic          res_fault,
  output logic          res_large
);
  localparam int DIR_LO = OFF_W + TBL_W;
  localparam int STRIDE = 2;

  logic [AW-1:0] base_q;
  logic [AW-1:0] dir_addr;
  logic [AW-1:0] vaddr_q;
  logic          ent_valid;
  logic          ent_large;
  logic [AW-1:0] tbl_addr;
  logic [AW-1:0] small_pa;
  logic [AW-1:0] large_pa;

  pt_base_reg #(.AW(AW)) u_base (
    .clk(clk), .rst_n(rst_n), .load(base_load), .value(base_value), .base(base_q)
  );

  assign dir_addr = base_q + (AW'(req_vaddr[DIR_LO+DIR_W-1:DIR_LO]) << STRIDE);

  pt_entry_dec #(
    .AW(AW), .OFF_W(OFF_W), .TBL_W(TBL_W), .VALID_BIT(VALID_BIT), .LARGE_BIT(LARGE_BIT)
  ) u_dec (
    .entry(mem_rsp_data), .vaddr(vaddr_q), .ent_valid(ent_valid), .ent_large(ent_large),
    .tbl_addr(tbl_addr), .small_pa(small_pa), .large_pa(large_pa)
  );

  pt_walk_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .dir_addr(dir_addr),
    .req_ready(req_ready), .vaddr_q(vaddr_q),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .ent_valid(ent_valid), .ent_large(ent_large), .tbl_addr(tbl_addr),
    .small_pa(small_pa), .large_pa(large_pa),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
    .res_fault(res_fault), .res_large(res_large)
  );
endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic          mem_rsp_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [AW-1:0] res_paddr,
  input logic          res_fault,
  input logic          res_large
);
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req_valid && mem_rsp_ready)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R8
  AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> mem_rsp_ready); // R8
  AST_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !res_valid && !mem_req_valid && !mem_rsp_ready); // R9
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_paddr) && $stable(res_fault) && $stable(res_large)); // R10
  AST_RES_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_ready |=> req_ready); // R10
  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> res_paddr == '0 && !res_large); // R5
endmodule

bind pt_walker pt_walker_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
  .mem_rsp_ready(mem_rsp_ready), .res_valid(res_valid), .res_ready(res_ready),
  .res_paddr(res_paddr), .res_fault(res_fault), .res_large(res_large)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        base_load;
  logic [31:0] base_value;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic        mem_rsp_ready;
  logic [31:0] mem_rsp_data;
  logic        res_valid;
  logic        res_ready;
  logic [31:0] res_paddr;
  logic        res_fault;
  logic        res_large;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_value(base_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
    .res_fault(res_fault), .res_large(res_large)
  );

  // memory model
  logic [31:0] mk [8];
  logic [31:0] mv [8];
  int          mn = 0;
  logic [31:0] rlog [8];
  int          nreads = 0;
  int          req_stall = 0;
  int          rsp_delay = 0;

  function automatic logic [31:0] lookup(input logic [31:0] a);
    for (int i = 0; i < 8; i++) if (i < mn && mk[i] == a) return mv[i];
    return 32'h0;
  endfunction

  task automatic put_mem(input logic [31:0] a, input logic [31:0] v);
    mk[mn] = a; mv[mn] = v; mn++;
  endtask

  task automatic clear_mem();
    mn = 0; nreads = 0;
  endtask

  initial begin
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = 32'h0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        repeat (req_stall) @(negedge clk);
        mem_req_ready = 1'b1;
        if (nreads < 8) rlog[nreads] = mem_req_addr;
        mem_rsp_data = lookup(mem_req_addr);
        nreads++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (rsp_delay) @(negedge clk);
        mem_rsp_valid = 1'b1;
        while (!mem_rsp_ready) @(negedge clk);
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] dir_of(input logic [31:0] b, input logic [31:0] va);
    return b + {20'h0, va[31:22], 2'b00};
  endfunction

  function automatic logic [31:0] tbl_of(input logic [31:0] pde, input logic [31:0] va);
    return {pde[31:12], 12'h0} + {20'h0, va[21:12], 2'b00};
  endfunction

  task automatic load_base(input logic [31:0] b);
    @(negedge clk);
    base_load = 1'b1; base_value = b;
    @(negedge clk);
    base_load = 1'b0;
  endtask

  task automatic issue(input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_res();
    while (!res_valid) @(negedge clk);
  endtask

  task automatic take_res();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 req_ready", {31'h0, req_ready}, 32'h1);
    chk("R12 res_valid", {31'h0, res_valid}, 32'h0);
    chk("R12 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
    chk("R12 mem_rsp_ready", {31'h0, mem_rsp_ready}, 32'h0);
    clear_mem();
    put_mem(32'h0000_0004, 32'h0040_0081);
    issue(32'h0040_0abc);
    wait_res();
    chk("R12 base zero dir addr", rlog[0], 32'h0000_0004);
    take_res();
  endtask

  task automatic t_small(input logic [31:0] b, input logic [31:0] va,
                         input logic [31:0] pde, input logic [31:0] pte, input string tag);
    clear_mem();
    load_base(b);
    put_mem(dir_of(b, va), pde);
    put_mem(tbl_of(pde, va), pte);
    issue(va);
    wait_res();
    chk({"R1 dir addr ", tag}, rlog[0], dir_of(b, va));
    chk({"R2 tbl addr ", tag}, rlog[1], tbl_of(pde, va));
    chk({"R3 paddr ", tag}, res_paddr, {pte[31:12], va[11:0]});
    chk({"R3 flags ", tag}, {30'h0, res_fault, res_large}, 32'h0);
    chk({"R3 reads ", tag}, nreads, 2);
    take_res();
  endtask

  task automatic t_large();
    logic [31:0] b, va, pde;
    b = 32'h0003_0000; va = 32'h0C87_1234; pde = 32'h0840_0083;
    clear_mem();
    load_base(b);
    put_mem(dir_of(b, va), pde);
    issue(va);
    wait_res();
    chk("R4 paddr", res_paddr, {pde[31:22], va[21:0]});
    chk("R4 large", {31'h0, res_large}, 32'h1);
    chk("R4 fault", {31'h0, res_fault}, 32'h0);
    chk("R4 reads", nreads, 1);
    take_res();
  endtask

  task automatic t_dir_fault(input logic [31:0] pde, input string tag);
    logic [31:0] va;
    va = 32'h8012_3456;
    clear_mem();
    put_mem(dir_of(32'h0003_0000, va), pde);
    issue(va);
    wait_res();
    chk({"R5 fault ", tag}, {30'h0, res_fault, res_large}, 32'h2);
    chk({"R5 paddr ", tag}, res_paddr, 32'h0);
    chk({"R5 reads ", tag}, nreads, 1);
    take_res();
  endtask

  task automatic t_tbl_fault();
    logic [31:0] b, va, pde;
    b = 32'h0003_0000; va = 32'h4055_5321; pde = 32'h0007_7001;
    clear_mem();
    put_mem(dir_of(b, va), pde);
    put_mem(tbl_of(pde, va), 32'hFFFF_F080);
    issue(va);
    wait_res();
    chk("R6 fault", {31'h0, res_fault}, 32'h1);
    chk("R6 paddr", res_paddr, 32'h0);
    chk("R6 reads", nreads, 2);
    take_res();
  endtask

  task automatic t_hold();
    logic [31:0] va, held;
    int n0;
    va = 32'h0040_1123;
    req_stall = 2; rsp_delay = 3;
    t_small(32'h0005_0000, va, 32'h0009_9001, 32'h0123_4001, "stall");
    req_stall = 0; rsp_delay = 0;
    clear_mem();
    put_mem(dir_of(32'h0005_0000, va), 32'h0009_9001);
    put_mem(tbl_of(32'h0009_9001, va), 32'h0AAA_A001);
    issue(va);
    wait_res();
    held = res_paddr;
    n0 = nreads;
    req_valid = 1'b1; req_vaddr = 32'hFFC0_0000;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk("R9 req_ready low while held", {31'h0, req_ready}, 32'h0);
      chk("R10 result held", {res_valid, res_paddr[30:0]}, {1'b1, held[30:0]});
    end
    chk("R9 no read started", nreads, n0);
    req_valid = 1'b0;
    take_res();
    chk("R10 idle after take", {31'h0, req_ready}, 32'h1);
  endtask

  task automatic t_base_mid();
    logic [31:0] va;
    va = 32'h0100_0000;
    req_stall = 4;
    clear_mem();
    put_mem(dir_of(32'h0005_0000, va), 32'h0400_0081);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    req_valid = 1'b0;
    base_load = 1'b1; base_value = 32'h0006_0000;
    @(negedge clk);
    base_load = 1'b0;
    wait_res();
    chk("R11 walk keeps old base", rlog[0], dir_of(32'h0005_0000, va));
    take_res();
    req_stall = 0;
    clear_mem();
    issue(va);
    wait_res();
    chk("R11 next walk new base", rlog[0], dir_of(32'h0006_0000, va));
    take_res();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; base_load = 1'b0; base_value = 32'h0;
    req_valid = 1'b0; req_vaddr = 32'h0; res_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small(32'h0001_0000, 32'h1234_5678, 32'h0002_0001, 32'h0ABC_D001, "basic");
    t_small(32'h0001_0800, 32'hFFFF_FFFF, 32'h00F0_0001, 32'h7654_3001, "max idx");
    t_small(32'h0001_0000, 32'h0000_3ABC, 32'h0002_0001, 32'h0333_3081, "R7 pte bit7");
    t_large();
    t_dir_fault(32'h0840_0080, "R5 bit7 set");
    t_dir_fault(32'h0840_0000, "plain");
    t_tbl_fault();
    t_hold();
    t_base_mid();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule